// File: doc/BRIEF.md
# Half-Duplex Transmit Statistics Counters

This block keeps six saturating event counters for the transmit side of an Ethernet MAC. It watches the transmitter's enable line, the carrier-sense input, collision pulses, the end-of-packet strobe with its success flag, and defer-event pulses tagged with a reason code. From these it counts collisions, packets that collided many times, collisions that came too late, packets abandoned after sixteen collisions, deferred starts, and good packets sent without ever seeing carrier. Each counter is `CNT_W` bits wide (32 by default), starts at zero and stops at all ones.

The block measures the slot-time window itself. A bit-time tick input, pulsing once per bit time, advances a timer that restarts on every rising edge of the transmit enable. A packet may take several attempts, because the enable line drops and rises again between backoff retries. The per-packet collision tally therefore restarts only on the first rising edge after an end-of-packet strobe, while the slot timer and the carrier-seen flag restart on every attempt. Software reads a counter by placing its index on `rd_addr`. The value appears on `rd_data` one clock later. A one-cycle `clear_stb` zeroes the whole bank.

Top module: `hdstat_counters`

## Requirements
- R1: After reset every counter reads zero. A read returns, on the clock after `rd_addr` is presented, the counter at that index: 0 excessive-collision, 1 multiple-collision, 2 late-collision, 3 total-collision, 4 defer, 5 no-carrier.
- R2: The total-collision counter adds one for every cycle in which `collision` is high while counting is allowed, and no counter ever changes by more than one per clock.
- R3: The collision counters (indices 0 to 3) and the tally behind them only move while both `xmit_on` and `half_duplex` are high.
- R4: With `coll_limit` at 16 or above, the excessive-collision counter adds one on the sixteenth collision of a packet, and only once for that packet.
- R5: With `coll_limit` below 16, the excessive-collision counter never increments.
- R6: On `done_stb` with `done_ok` high, the multiple-collision counter adds one when the packet's tally is from 2 to 15. A tally of 1 or of 16 and more does not count, and neither does a failed packet.
- R7: A collision counts as late when at least `SLOT_BITS` ticks have been seen since the current attempt's enable rose. A collision after `SLOT_BITS`-1 ticks is not late.
- R8: While `xmit_on` is high, a `defer_stb` pulse adds one to the defer counter when `defer_why` is a valid reason code: 0 busy medium, 1 inter-packet gap, 2 half-duplex deferral, 3 pause received, 4 link down. Codes 5 to 7, and any pulse while `xmit_on` is low, do not count.
- R9: A defer pulse with code 1 while `defer_streaming` is high does not count. Other codes with `defer_streaming` high still count.
- R10: On `done_stb` with `done_ok` and `xmit_on` high, the no-carrier counter adds one if `carrier_in` was not high at any cycle of the attempt with fewer than `SLOT_BITS` ticks elapsed.
- R11: The collision tally restarts on the first rising edge of `xmit_active` after a `done_stb`. Later rising edges within the same packet keep it.
- R12: A counter that reaches all ones stays there on further events.
- R13: `clear_stb` zeroes every counter on the next clock and wins over an event in the same cycle.
- R14: Reads of indices 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xmit_active | input | 1 | Transmit enable from MAC to PHY; a rising edge starts an attempt |
| carrier_in | input | 1 | Carrier sense from the PHY |
| collision | input | 1 | One-cycle pulse per collision seen |
| bit_tick | input | 1 | One pulse per bit time |
| done_stb | input | 1 | End-of-packet strobe |
| done_ok | input | 1 | Packet ended successfully (valid with `done_stb`) |
| defer_stb | input | 1 | Defer event pulse |
| defer_why | input | 3 | Defer reason code (see R8) |
| defer_streaming | input | 1 | Deferral occurred between back-to-back transmits |
| xmit_on | input | 1 | Transmit enabled |
| half_duplex | input | 1 | Link runs half duplex |
| coll_limit | input | 5 | Programmed collision threshold |
| clear_stb | input | 1 | Zero the whole counter bank |
| rd_addr | input | 3 | Counter index to read |
| rd_data | output | CNT_W | Registered read data |

## Verification
Collision traffic is driven as multi-attempt packets, with the enable line dropped and raised between collisions. This separates the per-packet tally from the per-attempt slot timer, and a failed packet followed by a one-collision good packet shows whether the tally restarts too late. Collisions are placed just before and just after the slot boundary to fix the late-collision edge. Sixteen-collision packets are run with the threshold at 16 and at 15, which keeps the excessive rule apart from the multiple rule. Defer pulses step through every reason code, with and without streaming, and carrier is raised inside, at, and never within the window. A second instance with three-bit counters shows saturation.

// File: rtl/hdstat_pkg.sv
package hdstat_pkg;

    // counter bank layout (read index order is part of the interface)
    localparam int NUM_CNT  = 6;
    localparam int IDX_W    = 3;
    localparam int I_EXCESS = 0;
    localparam int I_MULTI  = 1;
    localparam int I_LATE   = 2;
    localparam int I_TOTAL  = 3;
    localparam int I_DEFER  = 4;
    localparam int I_NOCRS  = 5;

    // per-packet collision tally
    localparam int TALLY_W     = 5;
    localparam int EXCESS_COLL = 16;

    typedef enum logic [2:0] {
        WHY_BUSY   = 3'd0,
        WHY_IPG    = 3'd1,
        WHY_HDX    = 3'd2,
        WHY_PAUSE  = 3'd3,
        WHY_LINKDN = 3'd4
    } defer_why_e;

    // attempt/packet state handed from the tracker to the decoder
    typedef struct packed {
        logic [TALLY_W-1:0] tally;     // collisions so far, already restarted on a new packet
        logic               crs_seen;  // carrier seen inside the slot window
        logic               late;      // slot window of this attempt has elapsed
    } pkt_state_t;

    function automatic logic why_valid(input logic [2:0] why);
        return why <= 3'(WHY_LINKDN);
    endfunction

    function automatic logic [TALLY_W-1:0] tally_bump(input logic [TALLY_W-1:0] t);
        return (t == '1) ? t : t + 1'b1;
    endfunction

endpackage

// File: rtl/hdstat_pkt_track.sv
module hdstat_pkt_track
    import hdstat_pkg::*;
#(
    parameter int SLOT_BITS = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       xmit_active,
    input  logic       carrier_in,
    input  logic       bit_tick,
    input  logic       col_ok,
    input  logic       done_stb,
    output pkt_state_t st
);
    localparam int EL_W = $clog2(SLOT_BITS + 1);
    localparam logic [EL_W-1:0] SLOT_END = EL_W'(SLOT_BITS);

    logic               act_q;
    logic               pkt_open_q;
    logic [EL_W-1:0]    elapsed_q;
    logic               crs_q;
    logic [TALLY_W-1:0] tally_q;
    logic               rise;
    logic               new_pkt;
    logic [TALLY_W-1:0] tally_base;

    assign rise       = xmit_active & ~act_q;
    assign new_pkt    = rise & ~pkt_open_q;
    assign tally_base = new_pkt ? '0 : tally_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q      <= 1'b0;
            pkt_open_q <= 1'b0;
            elapsed_q  <= '0;
            crs_q      <= 1'b0;
            tally_q    <= '0;
        end else begin
            act_q <= xmit_active;

            if (done_stb)
                pkt_open_q <= 1'b0;
            else if (rise)
                pkt_open_q <= 1'b1;

            if (rise)
                elapsed_q <= '0;
            else if (xmit_active && bit_tick && elapsed_q < SLOT_END)
                elapsed_q <= elapsed_q + 1'b1;

            if (rise)
                crs_q <= carrier_in;
            else if (xmit_active && carrier_in && elapsed_q < SLOT_END)
                crs_q <= 1'b1;

            tally_q <= col_ok ? tally_bump(tally_base) : tally_base;
        end
    end

    always_comb begin
        st.tally    = tally_base;
        st.crs_seen = crs_q;
        st.late     = ~rise & (elapsed_q >= SLOT_END);
    end

    // R11
    tally_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (xmit_active && !act_q && !pkt_open_q && !col_ok) |=> tally_q == '0);

    // R7
    window_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (elapsed_q == SLOT_END && !(xmit_active && !act_q)) |=> elapsed_q == SLOT_END);

endmodule

// File: rtl/hdstat_event_decode.sv
module hdstat_event_decode
    import hdstat_pkg::*;
(
    input  logic               col_ok,
    input  logic               xmit_on,
    input  logic               hdx_ok,
    input  logic               done_stb,
    input  logic               done_ok,
    input  logic               defer_stb,
    input  logic [2:0]         defer_why,
    input  logic               defer_streaming,
    input  logic [4:0]         coll_limit,
    input  pkt_state_t         st,
    output logic [NUM_CNT-1:0] inc
);
    localparam logic [TALLY_W-1:0] LAST_BEFORE_EXCESS = TALLY_W'(EXCESS_COLL - 1);
    localparam logic [TALLY_W-1:0] EXCESS_T           = TALLY_W'(EXCESS_COLL);

    logic good_done;
    logic ipg_stream;

    assign good_done  = done_stb & done_ok;
    assign ipg_stream = (defer_why == 3'(WHY_IPG)) & defer_streaming;

    always_comb begin
        inc          = '0;
        inc[I_TOTAL] = col_ok;
        inc[I_LATE]  = col_ok & st.late;
        inc[I_EXCESS] = col_ok && st.tally == LAST_BEFORE_EXCESS
                        && coll_limit >= 5'(EXCESS_COLL);
        inc[I_MULTI]  = good_done && hdx_ok
                        && st.tally > TALLY_W'(1) && st.tally < EXCESS_T;
        inc[I_DEFER]  = defer_stb && xmit_on && why_valid(defer_why) && !ipg_stream;
        inc[I_NOCRS]  = good_done && xmit_on && !st.crs_seen;
    end

endmodule

// File: rtl/hdstat_sat_bank.sv
module hdstat_sat_bank #(
    parameter int CNT_W = 32,
    parameter int N     = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic [N-1:0]          inc,
    output logic [N-1:0][CNT_W-1:0] cnt
);
    for (genvar i = 0; i < N; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst || clear)
                cnt[i] <= '0;
            else if (inc[i] && cnt[i] != '1)
                cnt[i] <= cnt[i] + 1'b1;
        end

        // R13
        clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
            clear |=> cnt[i] == '0);

        // R12
        no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt[i] == '1 && !clear) |=> cnt[i] == '1);

        // R2
        one_step_chk: assert property (@(posedge clk) disable iff (rst)
            !clear |=> (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) + 1'b1));
    end

endmodule

// File: rtl/hdstat_counters.sv
module hdstat_counters
    import hdstat_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int SLOT_BITS = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xmit_active,
    input  logic             carrier_in,
    input  logic             collision,
    input  logic             bit_tick,
    input  logic             done_stb,
    input  logic             done_ok,
    input  logic             defer_stb,
    input  logic [2:0]       defer_why,
    input  logic             defer_streaming,
    input  logic             xmit_on,
    input  logic             half_duplex,
    input  logic [4:0]       coll_limit,
    input  logic             clear_stb,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [CNT_W-1:0] rd_data
);
    logic                         hdx_ok;
    logic                         col_ok;
    pkt_state_t                   st;
    logic [NUM_CNT-1:0]           inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
    logic [CNT_W-1:0]             rd_mux;

    assign hdx_ok = xmit_on & half_duplex;
    assign col_ok = collision & hdx_ok;

    hdstat_pkt_track #(.SLOT_BITS(SLOT_BITS)) u_track (
        .clk         (clk),
        .rst         (rst),
        .xmit_active (xmit_active),
        .carrier_in  (carrier_in),
        .bit_tick    (bit_tick),
        .col_ok      (col_ok),
        .done_stb    (done_stb),
        .st          (st)
    );

    hdstat_event_decode u_dec (
        .col_ok          (col_ok),
        .xmit_on         (xmit_on),
        .hdx_ok          (hdx_ok),
        .done_stb        (done_stb),
        .done_ok         (done_ok),
        .defer_stb       (defer_stb),
        .defer_why       (defer_why),
        .defer_streaming (defer_streaming),
        .coll_limit      (coll_limit),
        .st              (st),
        .inc             (inc)
    );

    hdstat_sat_bank #(.CNT_W(CNT_W), .N(NUM_CNT)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .clear (clear_stb),
        .inc   (inc),
        .cnt   (cnt_all)
    );

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CNT; i++)
            if (rd_addr == IDX_W'(i))
                rd_mux = cnt_all[i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else
            rd_data <= rd_mux;
    end

    // R3
    gate_total_chk: assert property (@(posedge clk) disable iff (rst)
        (!(xmit_on && half_duplex) && !clear_stb) |=> $stable(cnt_all[I_TOTAL]));

    // R3
    gate_late_chk: assert property (@(posedge clk) disable iff (rst)
        (!(xmit_on && half_duplex) && !clear_stb) |=> $stable(cnt_all[I_LATE]));

    // R5
    low_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (coll_limit < 5'd16 && !clear_stb) |=> $stable(cnt_all[I_EXCESS]));

    // R9
    stream_ipg_chk: assert property (@(posedge clk) disable iff (rst)
        (defer_stb && defer_why == 3'd1 && defer_streaming && !clear_stb)
            |=> $stable(cnt_all[I_DEFER]));

    // R14
    blank_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr >= IDX_W'(NUM_CNT)) |=> rd_data == '0);

endmodule

// File: tb/sim_hdstat_counters.sv
`timescale 1ns/1ps
module sim_hdstat_counters;

    localparam int CW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xmit_active = 0, carrier_in = 0, collision = 0, bit_tick = 0;
    logic done_stb = 0, done_ok = 0, defer_stb = 0, defer_streaming = 0;
    logic [2:0] defer_why = 0;
    logic xmit_on = 1, half_duplex = 1, clear_stb = 0;
    logic [4:0] coll_limit = 5'd16;
    logic [2:0] rd_addr = 0;
    logic [CW-1:0] rd_data;
    logic [2:0] rd_data1;

    always #2.5 clk = ~clk;

    hdstat_counters u0 (
        .clk(clk), .rst(rst), .xmit_active(xmit_active), .carrier_in(carrier_in),
        .collision(collision), .bit_tick(bit_tick), .done_stb(done_stb), .done_ok(done_ok),
        .defer_stb(defer_stb), .defer_why(defer_why), .defer_streaming(defer_streaming),
        .xmit_on(xmit_on), .half_duplex(half_duplex), .coll_limit(coll_limit),
        .clear_stb(clear_stb), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    hdstat_counters #(.CNT_W(3), .SLOT_BITS(8)) u1 (
        .clk(clk), .rst(rst), .xmit_active(xmit_active), .carrier_in(carrier_in),
        .collision(collision), .bit_tick(bit_tick), .done_stb(done_stb), .done_ok(done_ok),
        .defer_stb(defer_stb), .defer_why(defer_why), .defer_streaming(defer_streaming),
        .xmit_on(xmit_on), .half_duplex(half_duplex), .coll_limit(coll_limit),
        .clear_stb(clear_stb), .rd_addr(rd_addr), .rd_data(rd_data1)
    );

    typedef struct {
        int            addr;
        logic [CW-1:0] exp;
        string         tag;
    } item_t;

    item_t q[$];
    int n_chk = 0, n_fail = 0;
    logic rd_v = 0, pend_q = 0;

    always @(posedge clk) pend_q <= rd_v;

    // monitor: compare read results against the queued expectations
    always @(negedge clk) begin
        if (pend_q && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if (rd_data !== it.exp) begin
                n_fail++;
                $display("FAIL %s: index %0d read %0d, expected %0d", it.tag, it.addr, rd_data, it.exp);
            end
        end
    end

    task automatic chk_rd(input int a, input logic [CW-1:0] e, input string tag);
        item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        q.push_back(it);
        rd_addr = 3'(a);
        rd_v = 1'b1;
        @(negedge clk);
        rd_v = 1'b0;
    endtask

    task automatic flush();
        repeat (2) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_clear();
        clear_stb = 1; @(negedge clk); clear_stb = 0; @(negedge clk);
    endtask

    task automatic tx_up();
        xmit_active = 1; @(negedge clk);
    endtask

    task automatic tx_down();
        xmit_active = 0; @(negedge clk);
    endtask

    task automatic coll();
        collision = 1; @(negedge clk); collision = 0; @(negedge clk);
    endtask

    task automatic finish_pkt(input logic ok);
        done_stb = 1; done_ok = ok; @(negedge clk); done_stb = 0; done_ok = 0; @(negedge clk);
    endtask

    task automatic ticks(input int n);
        bit_tick = 1; repeat (n) @(negedge clk); bit_tick = 0;
    endtask

    task automatic defer_ev(input logic [2:0] why, input logic strm);
        defer_stb = 1; defer_why = why; defer_streaming = strm;
        @(negedge clk);
        defer_stb = 0; defer_streaming = 0; defer_why = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung, expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        idle(3);
        rst = 0;
        idle(1);

        // R1 reset state, R14 blank indices
        for (int a = 0; a < 6; a++) chk_rd(a, 0, "R1 reset");
        chk_rd(6, 0, "R14 index 6");
        chk_rd(7, 0, "R14 index 7");
        flush();

        // three-attempt packet with early collisions, success (R2, R6, R10)
        do_clear();
        carrier_in = 1;
        tx_up(); coll(); tx_down();
        tx_up(); coll(); tx_down();
        tx_up(); coll(); idle(1);
        finish_pkt(1); tx_down();
        carrier_in = 0;
        chk_rd(3, 3, "R2 total");
        chk_rd(1, 1, "R6 multiple");
        chk_rd(2, 0, "R7 none late");
        chk_rd(0, 0, "R4 no excess");
        chk_rd(5, 0, "R10 carrier seen");
        flush();

        // slot boundary (R7)
        do_clear();
        carrier_in = 1;
        tx_up();
        ticks(511); coll();
        ticks(1); coll();
        tx_down(); finish_pkt(0);
        carrier_in = 0;
        chk_rd(2, 1, "R7 late boundary");
        chk_rd(3, 2, "R2 total late test");
        flush();

        // 17 collisions with limit 16 (R4)
        do_clear();
        coll_limit = 5'd16;
        for (int k = 0; k < 17; k++) begin tx_up(); coll(); tx_down(); end
        finish_pkt(0);
        chk_rd(0, 1, "R4 excess once");
        chk_rd(3, 17, "R2 total 17");
        chk_rd(1, 0, "R6 failed packet");
        flush();

        // 16 collisions with limit 15, then success (R5, R6)
        do_clear();
        coll_limit = 5'd15;
        for (int k = 0; k < 16; k++) begin tx_up(); coll(); tx_down(); end
        carrier_in = 1; tx_up(); carrier_in = 0;
        finish_pkt(1); tx_down();
        coll_limit = 5'd16;
        chk_rd(0, 0, "R5 limit below 16");
        chk_rd(1, 0, "R6 sixteen not multiple");
        chk_rd(3, 16, "R2 total 16");
        flush();

        // gating (R3)
        do_clear();
        half_duplex = 0;
        tx_up(); coll(); coll(); tx_down();
        half_duplex = 1; xmit_on = 0;
        tx_up(); coll(); tx_down();
        xmit_on = 1;
        chk_rd(3, 0, "R3 total gated");
        chk_rd(2, 0, "R3 late gated");
        flush();

        // defer reasons (R8, R9)
        do_clear();
        for (int w = 0; w < 5; w++) defer_ev(3'(w), 0);
        defer_ev(3'd1, 1);
        defer_ev(3'd0, 1);
        defer_ev(3'd5, 0);
        defer_ev(3'd7, 0);
        xmit_on = 0; defer_ev(3'd0, 0); xmit_on = 1;
        chk_rd(4, 6, "R8 R9 defer count");
        flush();

        // carrier watchdog (R10)
        do_clear();
        tx_up(); idle(3); finish_pkt(1); tx_down();
        chk_rd(5, 1, "R10 no carrier");
        flush();
        tx_up(); ticks(512); carrier_in = 1; idle(2); carrier_in = 0;
        finish_pkt(1); tx_down();
        chk_rd(5, 2, "R10 carrier after slot");
        flush();
        tx_up(); ticks(511); carrier_in = 1; idle(1); carrier_in = 0;
        finish_pkt(1); tx_down();
        chk_rd(5, 2, "R10 carrier at last slot bit");
        flush();

        // clear wins (R13)
        do_clear();
        coll(); coll();
        chk_rd(3, 2, "R13 before clear");
        flush();
        collision = 1; clear_stb = 1; @(negedge clk); collision = 0; clear_stb = 0; idle(1);
        chk_rd(3, 0, "R13 clear wins");
        flush();
        coll();
        chk_rd(3, 1, "R13 after clear");
        flush();

        // tally restart on new packet (R11)
        do_clear();
        carrier_in = 1;
        tx_up(); coll(); tx_down(); finish_pkt(0);
        tx_up(); coll(); finish_pkt(1); tx_down();
        carrier_in = 0;
        chk_rd(1, 0, "R11 tally restarted");
        chk_rd(3, 2, "R11 total");
        flush();

        // saturation on the narrow instance (R12)
        do_clear();
        for (int k = 0; k < 9; k++) coll();
        chk_rd(3, 9, "R12 wide total");
        flush();
        n_chk++;
        if (rd_data1 !== 3'd7) begin
            n_fail++;
            $display("FAIL R12 saturation: read %0d, expected 7", rd_data1);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule